// File: doc/BRIEF.md
# Converter Result Register Bank

This block keeps the results of a multi-channel data converter and the status flags that go with them. Each finished conversion arrives as one beat on a valid/ready stream that carries a channel number and a 16-bit sample. The beat is written into that channel's own result register and into a shared most-recent-result register. It sets that channel's end-of-conversion flag and a global data-ready flag. When data-ready goes from low to high, the block issues a one-cycle transfer request for a DMA engine. Any set flag whose enable bit is on drives an interrupt line.

Software-side logic reads results through two strobed ports, and both reads clear flags. The per-channel port returns the register of the channel held in a channel-select register. It clears only that channel's end-of-conversion flag. The most-recent port returns the last sample. It can also return the channel it came from. It clears data-ready and the end-of-conversion flag of that channel. The stream never applies back-pressure: `conv_ready` is held high, and every beat with `conv_valid` high is consumed in that cycle. A beat whose channel number is not below `NUM_CH` is consumed and discarded.

Top module: `rb_result_bank`

## Requirements
- R1: After reset, every result register, the most-recent register, the stored channel number, all end-of-conversion flags, data-ready, `irq` and `dma_req` are zero.
- R2: A beat accepted for channel c < NUM_CH writes its data into channel c's register and into the most-recent register, and both are readable from the next cycle.
- R3: With `tag_en` high, `rd_last_tag` shows the channel of the most recent accepted beat. With `tag_en` low it reads zero.
- R4: An accepted beat for channel c sets `eoc_flags[c]` and `drdy` from the next cycle.
- R5: `dma_req` is high for exactly one cycle, in the cycle that `drdy` rises. An accepted beat that arrives while `drdy` is already high produces no request.
- R6: A `rd_chan_stb` read returns the register of the selected channel. It clears only that channel's end-of-conversion flag and leaves `drdy` and all other flags unchanged.
- R7: A `rd_last_stb` read returns the most recent data. It clears `drdy` and the end-of-conversion flag of the stored last channel.
- R8: When a set and a clear hit the same flag in one cycle, the set wins and the flag stays high.
- R9: `irq` is high exactly when some `eoc_flags[i]` with `irq_en_eoc[i]` high is set, or when `drdy` and `irq_en_drdy` are both high.
- R10: `conv_ready` is always high. A beat whose channel is NUM_CH or more changes no register and no flag.
- R11: The channel-select register loads `sel_wdata` on `sel_we`. If it holds a channel that is NUM_CH or more, `rd_chan_data` reads zero and `rd_chan_stb` clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_valid | input | 1 | Conversion beat valid |
| conv_ready | output | 1 | Always high; the bank never stalls |
| conv_chan | input | CH_W | Channel of the beat |
| conv_data | input | DATA_W | Sample of the beat |
| tag_en | input | 1 | Show the last channel on rd_last_tag |
| sel_we | input | 1 | Load the channel-select register |
| sel_wdata | input | CH_W | New channel-select value |
| rd_chan_stb | input | 1 | Per-channel read strobe (clears a flag) |
| rd_chan_data | output | DATA_W | Register of the selected channel |
| rd_last_stb | input | 1 | Most-recent read strobe (clears flags) |
| rd_last_data | output | DATA_W | Most recent sample |
| rd_last_tag | output | CH_W | Channel of the most recent sample, or zero |
| eoc_flags | output | NUM_CH | Per-channel end-of-conversion flags |
| drdy | output | 1 | Global data-ready flag |
| irq_en_eoc | input | NUM_CH | Interrupt enables for the channel flags |
| irq_en_drdy | input | 1 | Interrupt enable for data-ready |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | One-cycle DMA transfer request |

## Verification
The bound checker checks these properties on every cycle:
- flags are set after an accepted beat;
- the most-recent data follows the accepted beat;
- `dma_req` pulses for one cycle on the rise of `drdy`;
- a most-recent read with no new beat drops `drdy`;
- out-of-range beats leave the flags untouched;
- the tag field is zero when tagging is off;
- `irq` never rises without a set flag.

The bench scenarios cover the behaviours that depend on history:
- which flag a read clears, which depends on the select register or the stored last channel;
- set-over-clear collisions on the same channel;
- per-enable masking of `irq`;
- the absence of a request when `drdy` is already high;
- reads through an out-of-range select value.

// File: rtl/rb_pkg.sv
package rb_pkg;
  localparam int RB_DEF_NUM_CH = 6;
  localparam int RB_DEF_DATA_W = 16;

  // channel index width, never below one bit
  function automatic int rb_ch_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/rb_store.sv
module rb_store #(
  parameter int NUM_CH = 6,
  parameter int DATA_W = 16,
  parameter int CH_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] wr_vec,
  input  logic              wr_any,
  input  logic [CH_W-1:0]   wr_chan,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [CH_W-1:0]   rd_sel,
  input  logic              rd_sel_ok,
  output logic [DATA_W-1:0] chan_rdata,
  output logic [DATA_W-1:0] last_data,
  output logic [CH_W-1:0]   last_chan
);
  logic [DATA_W-1:0] res_q [NUM_CH];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_res
    always_ff @(posedge clk) begin
      if (!rst_n)         res_q[i] <= '0;
      else if (wr_vec[i]) res_q[i] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_data <= '0;
      last_chan <= '0;
    end else if (wr_any) begin
      last_data <= wr_data;
      last_chan <= wr_chan;
    end
  end

  always_comb begin
    chan_rdata = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (rd_sel_ok && (rd_sel == CH_W'(i))) chan_rdata = res_q[i];
  end
endmodule

// File: rtl/rb_flags.sv
module rb_flags #(
  parameter int NUM_CH = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] set_vec,
  input  logic [NUM_CH-1:0] clr_vec,
  input  logic              set_any,
  input  logic              clr_drdy,
  output logic [NUM_CH-1:0] eoc_q,
  output logic              drdy_q,
  output logic              dma_q
);
  logic [NUM_CH-1:0] eoc_d;
  logic              drdy_d;

  // set has priority over clear on every flag
  always_comb begin
    eoc_d  = (eoc_q & ~clr_vec) | set_vec;
    drdy_d = (drdy_q & ~clr_drdy) | set_any;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eoc_q  <= '0;
      drdy_q <= 1'b0;
      dma_q  <= 1'b0;
    end else begin
      eoc_q  <= eoc_d;
      drdy_q <= drdy_d;
      dma_q  <= drdy_d & ~drdy_q;
    end
  end
endmodule

// File: rtl/rb_irq.sv
module rb_irq #(
  parameter int NUM_CH = 6
) (
  input  logic [NUM_CH-1:0] eoc,
  input  logic [NUM_CH-1:0] en_eoc,
  input  logic              drdy,
  input  logic              en_drdy,
  output logic              irq
);
  always_comb irq = (|(eoc & en_eoc)) | (drdy & en_drdy);
endmodule

// File: rtl/rb_result_bank.sv
module rb_result_bank
  import rb_pkg::*;
#(
  parameter int NUM_CH = RB_DEF_NUM_CH,
  parameter int DATA_W = RB_DEF_DATA_W,
  parameter int CH_W   = rb_ch_width(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_valid,
  output logic              conv_ready,
  input  logic [CH_W-1:0]   conv_chan,
  input  logic [DATA_W-1:0] conv_data,
  input  logic              tag_en,
  input  logic              sel_we,
  input  logic [CH_W-1:0]   sel_wdata,
  input  logic              rd_chan_stb,
  output logic [DATA_W-1:0] rd_chan_data,
  input  logic              rd_last_stb,
  output logic [DATA_W-1:0] rd_last_data,
  output logic [CH_W-1:0]   rd_last_tag,
  output logic [NUM_CH-1:0] eoc_flags,
  output logic              drdy,
  input  logic [NUM_CH-1:0] irq_en_eoc,
  input  logic              irq_en_drdy,
  output logic              irq,
  output logic              dma_req
);
  localparam logic [CH_W:0] CH_LIMIT = (CH_W+1)'(NUM_CH);

  logic [CH_W-1:0]   sel_q;
  logic              sel_ok;
  logic              beat_ok;
  logic [NUM_CH-1:0] set_vec;
  logic [NUM_CH-1:0] clr_vec;
  logic [CH_W-1:0]   last_chan;

  assign conv_ready = 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n)      sel_q <= '0;
    else if (sel_we) sel_q <= sel_wdata;
  end

  always_comb begin
    sel_ok  = {1'b0, sel_q} < CH_LIMIT;
    beat_ok = conv_valid && ({1'b0, conv_chan} < CH_LIMIT);
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
    always_comb begin
      set_vec[i] = beat_ok && (conv_chan == CH_W'(i));
      clr_vec[i] = (rd_chan_stb && sel_ok && (sel_q == CH_W'(i))) ||
                   (rd_last_stb && (last_chan == CH_W'(i)));
    end
  end

  rb_store #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .CH_W(CH_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_vec     (set_vec),
    .wr_any     (beat_ok),
    .wr_chan    (conv_chan),
    .wr_data    (conv_data),
    .rd_sel     (sel_q),
    .rd_sel_ok  (sel_ok),
    .chan_rdata (rd_chan_data),
    .last_data  (rd_last_data),
    .last_chan  (last_chan)
  );

  rb_flags #(.NUM_CH(NUM_CH)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_vec  (set_vec),
    .clr_vec  (clr_vec),
    .set_any  (beat_ok),
    .clr_drdy (rd_last_stb),
    .eoc_q    (eoc_flags),
    .drdy_q   (drdy),
    .dma_q    (dma_req)
  );

  rb_irq #(.NUM_CH(NUM_CH)) u_irq (
    .eoc     (eoc_flags),
    .en_eoc  (irq_en_eoc),
    .drdy    (drdy),
    .en_drdy (irq_en_drdy),
    .irq     (irq)
  );

  assign rd_last_tag = tag_en ? last_chan : '0;
endmodule

// File: rtl/rb_checker.sv
module rb_checker #(
  parameter int NUM_CH = 6,
  parameter int DATA_W = 16,
  parameter int CH_W   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              conv_valid,
  input logic              conv_ready,
  input logic [CH_W-1:0]   conv_chan,
  input logic [DATA_W-1:0] conv_data,
  input logic              tag_en,
  input logic              rd_chan_stb,
  input logic              rd_last_stb,
  input logic [DATA_W-1:0] rd_last_data,
  input logic [CH_W-1:0]   rd_last_tag,
  input logic [NUM_CH-1:0] eoc_flags,
  input logic              drdy,
  input logic              irq,
  input logic              dma_req
);
  localparam logic [CH_W:0] LIM = (CH_W+1)'(NUM_CH);
  logic in_rng;
  assign in_rng = {1'b0, conv_chan} < LIM;

  assert_flags_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_valid && in_rng) |=> (eoc_flags[$past(conv_chan)] && drdy));

  assert_last_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_valid && in_rng) |=> (rd_last_data == $past(conv_data)));

  assert_dma_on_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (drdy && !$past(drdy)) |-> dma_req);

  assert_dma_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |=> !dma_req);

  assert_dma_needs_drdy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> drdy);

  assert_last_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_last_stb && !(conv_valid && in_rng)) |=> !drdy);

  assert_bad_chan_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_valid && !in_rng && !rd_chan_stb && !rd_last_stb) |=>
      ($stable(eoc_flags) && $stable(drdy)));

  assert_always_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    conv_ready);

  assert_tag_off_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !tag_en |-> (rd_last_tag == '0));

  assert_irq_has_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((|eoc_flags) || drdy));
endmodule

bind rb_result_bank rb_checker #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .CH_W(CH_W)) u_rb_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .conv_valid   (conv_valid),
  .conv_ready   (conv_ready),
  .conv_chan    (conv_chan),
  .conv_data    (conv_data),
  .tag_en       (tag_en),
  .rd_chan_stb  (rd_chan_stb),
  .rd_last_stb  (rd_last_stb),
  .rd_last_data (rd_last_data),
  .rd_last_tag  (rd_last_tag),
  .eoc_flags    (eoc_flags),
  .drdy         (drdy),
  .irq          (irq),
  .dma_req      (dma_req)
);

// File: tb/rb_result_bank_bench.sv
module rb_result_bank_bench;
  localparam int NCH = 6;
  localparam int DW  = 16;
  localparam int CW  = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          conv_valid = 1'b0;
  logic          conv_ready;
  logic [CW-1:0] conv_chan = '0;
  logic [DW-1:0] conv_data = '0;
  logic          tag_en = 1'b1;
  logic          sel_we = 1'b0;
  logic [CW-1:0] sel_wdata = '0;
  logic          rd_chan_stb = 1'b0;
  logic [DW-1:0] rd_chan_data;
  logic          rd_last_stb = 1'b0;
  logic [DW-1:0] rd_last_data;
  logic [CW-1:0] rd_last_tag;
  logic [NCH-1:0] eoc_flags;
  logic          drdy;
  logic [NCH-1:0] irq_en_eoc = '0;
  logic          irq_en_drdy = 1'b0;
  logic          irq;
  logic          dma_req;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  rb_result_bank #(.NUM_CH(NCH), .DATA_W(DW)) u_rb_result_bank (
    .clk(clk), .rst_n(rst_n), .conv_valid(conv_valid), .conv_ready(conv_ready),
    .conv_chan(conv_chan), .conv_data(conv_data), .tag_en(tag_en),
    .sel_we(sel_we), .sel_wdata(sel_wdata), .rd_chan_stb(rd_chan_stb),
    .rd_chan_data(rd_chan_data), .rd_last_stb(rd_last_stb),
    .rd_last_data(rd_last_data), .rd_last_tag(rd_last_tag),
    .eoc_flags(eoc_flags), .drdy(drdy), .irq_en_eoc(irq_en_eoc),
    .irq_en_drdy(irq_en_drdy), .irq(irq), .dma_req(dma_req)
  );

  // vector: [18:16] channel, [15:0] sample
  localparam logic [18:0] VECS [8] = '{
    {3'd0, 16'h0001}, {3'd1, 16'hFFFF}, {3'd2, 16'h8000}, {3'd3, 16'h1234},
    {3'd4, 16'hA5A5}, {3'd5, 16'h7FFE}, {3'd5, 16'h0F0F}, {3'd0, 16'hC3C3}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic convert(input logic [CW-1:0] ch, input logic [DW-1:0] d, output logic dma_seen);
    @(negedge clk);
    conv_valid = 1'b1; conv_chan = ch; conv_data = d;
    @(posedge clk); #1 dma_seen = dma_req;
    @(negedge clk);
    conv_valid = 1'b0;
  endtask

  task automatic select(input logic [CW-1:0] ch);
    @(negedge clk); sel_we = 1'b1; sel_wdata = ch;
    @(negedge clk); sel_we = 1'b0;
  endtask

  task automatic read_chan(output logic [DW-1:0] d);
    @(negedge clk); rd_chan_stb = 1'b1; #1 d = rd_chan_data;
    @(negedge clk); rd_chan_stb = 1'b0;
  endtask

  task automatic read_last(output logic [DW-1:0] d, output logic [CW-1:0] t);
    @(negedge clk); rd_last_stb = 1'b1; #1 d = rd_last_data; t = rd_last_tag;
    @(negedge clk); rd_last_stb = 1'b0;
  endtask

  initial begin
    logic          dm;
    logic [DW-1:0] rd;
    logic [CW-1:0] tg;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 eoc", 32'(eoc_flags), 0);
    chk("R1 drdy", 32'(drdy), 0);
    chk("R1 dma", 32'(dma_req), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 last", 32'(rd_last_data), 0);
    chk("R1 chan", 32'(rd_chan_data), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 tag", 32'(rd_last_tag), 0);

    for (int v = 0; v < 8; v++) begin
      logic [CW-1:0] c;
      logic [DW-1:0] d;
      c = VECS[v][18:16];
      d = VECS[v][15:0];
      convert(c, d, dm);
      chk("R5 dma rise", 32'(dm), 1);
      @(negedge clk);
      chk("R5 dma single", 32'(dma_req), 0);
      chk("R4 eoc set", 32'(eoc_flags), 32'(1 << c));
      chk("R4 drdy set", 32'(drdy), 1);
      chk("R3 tag", 32'(rd_last_tag), 32'(c));
      select(c);
      read_chan(rd);
      chk("R2 chan data", 32'(rd), 32'(d));
      chk("R6 eoc cleared", 32'(eoc_flags), 0);
      chk("R6 drdy kept", 32'(drdy), 1);
      read_last(rd, tg);
      chk("R2 last data", 32'(rd), 32'(d));
      chk("R7 drdy cleared", 32'(drdy), 0);
    end

    // R6: only the selected channel is cleared
    convert(3'd1, 16'h1111, dm);
    convert(3'd2, 16'h2222, dm);
    select(3'd1);
    read_chan(rd);
    chk("R6 data", 32'(rd), 32'h1111);
    chk("R6 other eoc kept", 32'(eoc_flags), 32'b000100);
    chk("R6 drdy kept", 32'(drdy), 1);
    // R7: last read clears last channel and drdy
    read_last(rd, tg);
    chk("R7 data", 32'(rd), 32'h2222);
    chk("R7 tag", 32'(tg), 2);
    chk("R7 eoc", 32'(eoc_flags), 0);
    chk("R7 drdy", 32'(drdy), 0);

    // R5: no request while drdy already high
    convert(3'd3, 16'h3333, dm);
    chk("R5 first", 32'(dm), 1);
    convert(3'd4, 16'h4444, dm);
    chk("R5 no second", 32'(dm), 0);

    // R8: set wins against clear from a last read
    @(negedge clk);
    conv_valid = 1'b1; conv_chan = 3'd4; conv_data = 16'hA4A4; rd_last_stb = 1'b1;
    @(negedge clk);
    conv_valid = 1'b0; rd_last_stb = 1'b0;
    chk("R8 eoc kept", 32'(eoc_flags), 32'b011000);
    chk("R8 drdy kept", 32'(drdy), 1);
    chk("R8 data", 32'(rd_last_data), 32'hA4A4);
    @(negedge clk);
    conv_valid = 1'b1; conv_chan = 3'd2; conv_data = 16'h5252; rd_last_stb = 1'b1;
    @(negedge clk);
    conv_valid = 1'b0; rd_last_stb = 1'b0;
    chk("R8 clear old set new", 32'(eoc_flags), 32'b001100);
    chk("R8 drdy", 32'(drdy), 1);

    // R3: tag off reads zero
    tag_en = 1'b0; #1;
    chk("R3 tag off", 32'(rd_last_tag), 0);
    tag_en = 1'b1; #1;
    chk("R3 tag on", 32'(rd_last_tag), 2);

    // R9: interrupt masking
    @(negedge clk);
    chk("R9 all off", 32'(irq), 0);
    irq_en_eoc = 6'b000100; #1;
    chk("R9 eoc2 on", 32'(irq), 1);
    irq_en_eoc = 6'b000001; #1;
    chk("R9 eoc0 clear", 32'(irq), 0);
    irq_en_drdy = 1'b1; #1;
    chk("R9 drdy on", 32'(irq), 1);
    irq_en_eoc = '0; irq_en_drdy = 1'b0;

    // R10: out-of-range beat ignored
    convert(3'd7, 16'hDEAD, dm);
    @(negedge clk);
    chk("R10 ready", 32'(conv_ready), 1);
    chk("R10 eoc", 32'(eoc_flags), 32'b001100);
    chk("R10 last", 32'(rd_last_data), 32'h5252);
    chk("R10 tag", 32'(rd_last_tag), 2);

    // R11: out-of-range select
    select(3'd7);
    read_chan(rd);
    chk("R11 data zero", 32'(rd), 0);
    chk("R11 nothing cleared", 32'(eoc_flags), 32'b001100);
    select(3'd3);
    read_chan(rd);
    chk("R11 reselect", 32'(rd), 32'h3333);
    chk("R11 cleared 3", 32'(eoc_flags), 32'b000100);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(20 * 100000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule